// File: doc/BRIEF.md
# Pulse-Count Single-Wire Register Writer

This block turns activity on one idle-high control wire into register writes. The sender encodes each value as a number of low pulses, and a long high interval marks the end of a group of pulses, called a burst. The first burst of a write carries the register address. The second burst carries the data value. When a valid data burst ends, the block raises a one-cycle write strobe together with a 5-bit address and a 6-bit data value. A register file outside the block consumes these. The wire is sampled only by the block's clock, and the input passes through a two-flop synchroniser. Every time window is a parameter counted in clock cycles.

The same wire also switches the device on and off. A long high interval enables the device, and a long low interval disables it. A very long high interval puts the bus into standby. The block keeps track of whether the next burst is an address or data. It drops transfers whose pulse counts are out of range, and it returns to expecting an address when a timeout runs out.

The write output is a plain strobe with no ready input. The sender cannot be held off, so back-pressure is not possible. A consumer must accept the write in the cycle in which `wr_valid_o` is high.

Top module: `pulse_wire_writer`

## Requirements
- R1: A burst of K low pulses (K rising edges) carries the value K-1. After an address burst of Ka pulses and a data burst of Kd pulses, `wr_valid_o` is high for exactly one cycle, with `wr_addr_o`=Ka-1 and `wr_data_o`=Kd-1. The strobe appears HOLDD_MIN+3 clock edges after the edge that first samples `line_i` high at the end of the data burst.
- R2: An address burst of 1 to 32 pulses is accepted (addresses 0..31). A data burst of 1 to 64 pulses is accepted (data 0..63).
- R3: A high gap shorter than HOLDA_MIN+1 cycles (address phase) or HOLDD_MIN+1 cycles (data phase) does not end a burst. The pulses on both sides of the gap add to one count.
- R4: After a valid data hold, the next burst is always an address. Each write needs its own address burst.
- R5: If the line stays high for HOLDA_MAX+1 cycles after an accepted address and no data pulse arrives, the address is dropped. The next burst is then taken as an address.
- R6: A data burst of more than 64 pulses gives no strobe. The burst after it is taken as an address.
- R7: An address burst of more than 32 pulses gives no strobe. All later pulses are ignored until the line stays high for BUSRST_CYC+1 cycles. After that the next burst is an address.
- R8: `standby_o` is high while the device is enabled and the synchronised line has been high for more than STBY_CYC cycles. Entering standby makes the next burst an address.
- R9: While disabled, `dev_en_o` rises once the line has been high for SU_CYC+1 cycles. While enabled, `dev_en_o` falls once the line has been low for SD_CYC+1 cycles. No strobe is produced while the device is disabled.
- R10: During and right after reset, `dev_en_o`, `standby_o` and `wr_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, synchronous to clk |
| line_i | input | 1 | Idle-high single control wire (asynchronous) |
| dev_en_o | output | 1 | Device enabled |
| standby_o | output | 1 | Bus is in standby (long high while enabled) |
| wr_valid_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 5 | Register address of the write |
| wr_data_o | output | 6 | Data value of the write |

## Verification
The hardest condition to reach from the ports is a bus that has fallen out of step: a dropped address, an oversized burst, or a lock-out that waits for the bus-reset interval. From outside, all of these look like silence on the write strobe. To reach them, the stimulus builds bursts with chosen high-hold lengths just above and just below each window, and places them on both sides of an overlong address burst and an overlong data burst. It then sends an ordinary write that only lands at the right register if the block has recovered into the address phase. A behavioural model checks the enable, standby and strobe outputs against the design on every clock.

// File: rtl/pww_pkg.sv
package pww_pkg;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_DATA = 2'd1,
    PH_DROP = 2'd2
  } phase_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pww_sync.sv
module pww_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic dout_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], din_i};
  end

  assign dout_o = chain_q[STAGES-1];

endmodule

// File: rtl/pww_run_timer.sv
module pww_run_timer #(
  parameter int RUN_W   = 6,
  parameter int RUN_MAX = 61
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_i,
  output logic             lvl_o,
  output logic [RUN_W-1:0] run_o
);

  logic             lvl_q;
  logic [RUN_W-1:0] run_q;

  // run_q counts the cycles the registered level has been stable (0 = just changed)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else begin
      lvl_q <= lvl_i;
      if (lvl_i != lvl_q)                    run_q <= '0;
      else if (run_q != RUN_W'(RUN_MAX))     run_q <= run_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;
  assign run_o = run_q;

endmodule

// File: rtl/pww_fsm.sv
module pww_fsm
  import pww_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 6,
  parameter int RUN_W      = 6,
  parameter int SU_CYC     = 40,
  parameter int SD_CYC     = 60,
  parameter int HOLDA_MIN  = 6,
  parameter int HOLDA_MAX  = 16,
  parameter int HOLDD_MIN  = 6,
  parameter int BUSRST_CYC = 24,
  parameter int STBY_CYC   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_i,
  input  logic [RUN_W-1:0]  run_i,
  output logic              en_o,
  output logic              standby_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam int CNT_W      = DATA_W + 1;
  localparam int ADDR_LIMIT = 1 << ADDR_W;
  localparam int DATA_LIMIT = 1 << DATA_W;

  phase_e            ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              en_q;
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  logic rise, su_hit, sd_hit, sb_hit, ha_hit, hamax_hit, hd_hit, br_hit;

  assign rise      =  lvl_i && (run_i == '0);
  assign su_hit    =  lvl_i && (run_i == RUN_W'(SU_CYC));
  assign sd_hit    = !lvl_i && (run_i == RUN_W'(SD_CYC));
  assign sb_hit    =  lvl_i && (run_i == RUN_W'(STBY_CYC));
  assign ha_hit    =  lvl_i && (run_i == RUN_W'(HOLDA_MIN));
  assign hamax_hit =  lvl_i && (run_i == RUN_W'(HOLDA_MAX));
  assign hd_hit    =  lvl_i && (run_i == RUN_W'(HOLDD_MIN));
  assign br_hit    =  lvl_i && (run_i == RUN_W'(BUSRST_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_ADDR;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      vld_q <= 1'b0;
      if (!en_q) begin
        if (su_hit) begin
          en_q  <= 1'b1;
          ph_q  <= PH_ADDR;
          cnt_q <= '0;
        end
      end else if (sd_hit) begin
        en_q   <= 1'b0;
        ph_q   <= PH_ADDR;
        cnt_q  <= '0;
        addr_q <= '0;
        data_q <= '0;
      end else if (sb_hit) begin
        ph_q  <= PH_ADDR;
        cnt_q <= '0;
      end else begin
        unique case (ph_q)
          PH_ADDR: begin
            if (rise) begin
              if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            end else if (ha_hit && cnt_q != '0) begin
              cnt_q <= '0;
              if (cnt_q <= CNT_W'(ADDR_LIMIT)) begin
                addr_q <= ADDR_W'(cnt_q - 1'b1);
                ph_q   <= PH_DATA;
              end else begin
                ph_q <= PH_DROP;
              end
            end
          end
          PH_DATA: begin
            if (rise) begin
              if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            end else if (hd_hit && cnt_q != '0) begin
              cnt_q <= '0;
              ph_q  <= PH_ADDR;
              if (cnt_q <= CNT_W'(DATA_LIMIT)) begin
                data_q <= DATA_W'(cnt_q - 1'b1);
                vld_q  <= 1'b1;
              end
            end else if (hamax_hit && cnt_q == '0) begin
              ph_q <= PH_ADDR;
            end
          end
          PH_DROP: begin
            if (br_hit) ph_q <= PH_ADDR;
          end
          default: ph_q <= PH_ADDR;
        endcase
      end
    end
  end

  assign en_o       = en_q;
  assign standby_o  = en_q && lvl_i && (run_i >= RUN_W'(STBY_CYC));
  assign wr_valid_o = vld_q;
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_q;

  // R1
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R9
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !vld_q);

  // R7
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DROP) |=> !vld_q);

  // R8
  stby_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby_o) |=> (ph_q == PH_ADDR));

endmodule

// File: rtl/pulse_wire_writer.sv
module pulse_wire_writer #(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int SU_CYC      = 40,
  parameter int SD_CYC      = 60,
  parameter int HOLDA_MIN   = 6,
  parameter int HOLDA_MAX   = 16,
  parameter int HOLDD_MIN   = 6,
  parameter int BUSRST_CYC  = 24,
  parameter int STBY_CYC    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  output logic              dev_en_o,
  output logic              standby_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam int unsigned RUN_TOP = pww_pkg::max_u(pww_pkg::max_u(SU_CYC, SD_CYC),
                                    pww_pkg::max_u(pww_pkg::max_u(HOLDA_MAX, STBY_CYC),
                                    pww_pkg::max_u(BUSRST_CYC, pww_pkg::max_u(HOLDA_MIN, HOLDD_MIN))));
  localparam int RUN_MAX = int'(RUN_TOP) + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic             line_s;
  logic             lvl;
  logic [RUN_W-1:0] run;

  pww_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (line_i),
    .dout_o (line_s)
  );

  pww_run_timer #(.RUN_W(RUN_W), .RUN_MAX(RUN_MAX)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (line_s),
    .lvl_o (lvl),
    .run_o (run)
  );

  pww_fsm #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .RUN_W      (RUN_W),
    .SU_CYC     (SU_CYC),
    .SD_CYC     (SD_CYC),
    .HOLDA_MIN  (HOLDA_MIN),
    .HOLDA_MAX  (HOLDA_MAX),
    .HOLDD_MIN  (HOLDD_MIN),
    .BUSRST_CYC (BUSRST_CYC),
    .STBY_CYC   (STBY_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (lvl),
    .run_i      (run),
    .en_o       (dev_en_o),
    .standby_o  (standby_o),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

endmodule

// File: tb/test_pulse_wire_writer.sv
module test_pulse_wire_writer;

  localparam int SU = 40, SD = 60, HAMIN = 6, HAMAX = 16, HDMIN = 6, BR = 24, STBY = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_i = 1'b1;
  logic       dev_en_o, standby_o, wr_valid_o;
  logic [4:0] wr_addr_o;
  logic [5:0] wr_data_o;

  always #5 clk = ~clk;

  pulse_wire_writer #(
    .SU_CYC(SU), .SD_CYC(SD), .HOLDA_MIN(HAMIN), .HOLDA_MAX(HAMAX),
    .HOLDD_MIN(HDMIN), .BUSRST_CYC(BR), .STBY_CYC(STBY)
  ) i_pulse_wire_writer (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .dev_en_o(dev_en_o),
    .standby_o(standby_o), .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int qa[$], qd[$];

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: line delay, level age, and the write rules
  int m_s1, m_s2, m_lvl, m_run, m_en, m_ph, m_cnt, m_valid, m_addr, m_data;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_run = 0; m_en = 0; m_ph = 0;
      m_cnt = 0; m_valid = 0; m_addr = 0; m_data = 0;
    end else begin
      m_valid = 0;
      if (m_en == 0) begin
        if (m_lvl == 1 && m_run == SU) begin m_en = 1; m_ph = 0; m_cnt = 0; end
      end else if (m_lvl == 0 && m_run == SD) begin
        m_en = 0; m_ph = 0; m_cnt = 0; m_addr = 0; m_data = 0;
      end else if (m_lvl == 1 && m_run == STBY) begin
        m_ph = 0; m_cnt = 0;
      end else if (m_lvl == 1 && m_run == 0) begin
        if (m_ph != 2) m_cnt++;
      end else if (m_lvl == 1) begin
        if (m_ph == 0 && m_run == HAMIN && m_cnt > 0) begin
          if (m_cnt <= 32) begin m_addr = m_cnt - 1; m_ph = 1; end
          else m_ph = 2;
          m_cnt = 0;
        end else if (m_ph == 1 && m_run == HDMIN && m_cnt > 0) begin
          if (m_cnt <= 64) begin m_data = m_cnt - 1; m_valid = 1; end
          m_ph = 0; m_cnt = 0;
        end else if (m_ph == 1 && m_run == HAMAX && m_cnt == 0) begin
          m_ph = 0;
        end else if (m_ph == 2 && m_run == BR) begin
          m_ph = 0;
        end
      end
      if (m_s2 != m_lvl) m_run = 0; else m_run++;
      m_lvl = m_s2; m_s2 = m_s1; m_s1 = int'(line_i);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 strobe vs model", int'(wr_valid_o), m_valid);
      chk("R9 enable vs model", int'(dev_en_o), m_en);
      chk("R8 standby vs model", int'(standby_o), int'(m_en == 1 && m_lvl == 1 && m_run >= STBY));
      if (wr_valid_o) begin
        if (qa.size() == 0) begin
          chk("R4 unexpected write addr", int'(wr_addr_o), -1);
        end else begin
          chk("R1 write address", int'(wr_addr_o), qa.pop_front());
          chk("R2 write data", int'(wr_data_o), qd.pop_front());
        end
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // k low pulses of 2 cycles, high gaps of gap cycles, last high lasts hold cycles
  task automatic burst(input int k, input int gap, input int hold);
    for (int i = 0; i < k; i++) begin
      line_i = 1'b0; wait_n(2);
      line_i = 1'b1; wait_n((i == k - 1) ? hold : gap);
    end
  endtask

  task automatic send(input int a, input int d);
    qa.push_back(a); qd.push_back(d);
    burst(a + 1, 2, 10);
    burst(d + 1, 2, 10);
  endtask

  task automatic report();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    line_i = 1'b1;
    wait_n(5);
    // R10 reset state
    chk("R10 en in reset", int'(dev_en_o), 0);
    chk("R10 valid in reset", int'(wr_valid_o), 0);
    chk("R10 standby in reset", int'(standby_o), 0);
    rst_n = 1'b1;
    wait_n(2);
    chk("R10 en after reset", int'(dev_en_o), 0);
    // R9 enable after long high
    wait_n(50);
    chk("R9 enabled", int'(dev_en_o), 1);
    // R1, R2 ordinary writes and range ends
    send(2, 3);
    send(31, 63);
    send(0, 0);
    // R3 gaps just below the hold window
    qa.push_back(3); qd.push_back(1);
    burst(4, 5, 10);
    burst(2, 5, 10);
    // R4 back-to-back pairs
    send(5, 1);
    send(5, 2);
    // R5 address hold too long: dropped, next burst is address
    burst(8, 2, 20);
    qa.push_back(2); qd.push_back(5);
    burst(3, 2, 10);
    burst(6, 2, 10);
    // R7 oversized address, lock-out until bus reset
    burst(34, 2, 10);
    burst(4, 2, 10);
    burst(4, 2, 30);
    send(9, 12);
    // R6 oversized data discarded
    burst(1, 2, 10);
    burst(65, 2, 10);
    send(4, 4);
    // R8 standby after long high
    burst(3, 2, 45);
    chk("R8 standby asserted", int'(standby_o), 1);
    send(1, 1);
    // R9 disable after long low, no writes while disabled
    line_i = 1'b0; wait_n(70);
    chk("R9 disabled", int'(dev_en_o), 0);
    burst(3, 2, 10);
    burst(3, 2, 10);
    chk("R9 still disabled", int'(dev_en_o), 0);
    line_i = 1'b1; wait_n(50);
    chk("R9 re-enabled", int'(dev_en_o), 1);
    send(6, 7);
    wait_n(20);
    chk("R4 all expected writes seen", qa.size(), 0);
    report();
  end

endmodule